// File: doc/BRIEF.md
# MDIO management master

This block is the station-management end of a two-wire PHY management link. From a fast system clock it derives the management clock (MDC) with a fixed, parameterised divider. On request it serialises one read or write transaction onto the management data line, controls the line's tristate driver, and collects the 16 data bits a PHY returns on a read.

A user pulses `cmdStart` with the operation, the PHY and register addresses, the write data and a flag that drops the preamble. `busy` is high while the transaction runs. At the end, `done` pulses for one clock. On a read, `rdData` and `noResp` are updated at that moment. The master releases the line through the whole turnaround of a read. If the PHY fails to pull the second turnaround bit low, the master flags the transaction as unanswered.

Top module: `mdio_master`

## Requirements
- R1: Out of reset, and whenever `busy` is low, `mdc` is low and `mdioOe` is low; `busy`, `done` and `noResp` reset low.
- R2: With `cmdNoPre` low, the frame starts with 32 driven ones, one per MDC rising edge, for 64 MDC rising edges in all. With `cmdNoPre` high, the frame starts directly with the start pattern, for 32 rising edges in all.
- R3: After any preamble, the master drives, MSB first: the start bits 0 then 1; the opcode (1,0 for a read, 0,1 for a write); the 5-bit PHY address; then the 5-bit register address.
- R4: On a write (`cmdRead`=0), the master drives 1 then 0 in the two turnaround bit times, then `cmdWrData` MSB first, with the driver enabled for every bit of the frame.
- R5: On a read, the driver is disabled for both turnaround bits and all 16 data bits. `mdioIn` is sampled on each MDC rise, and the 16 data bits appear MSB first on `rdData` when `done` pulses.
- R6: On a read whose second turnaround bit samples as 1, `noResp` becomes 1 and `rdData` becomes 16'hFFFF. A read whose second turnaround bit samples 0 sets `noResp` to 0, and so does any write.
- R7: `mdioOut` and `mdioOe` never change while `mdc` is high, or at the edge where it rises; they change only together with a falling MDC, or at frame start while MDC is low.
- R8: Each MDC high phase lasts CLK_DIV/2 system clocks and each bit lasts CLK_DIV clocks. `done` is a one-clock pulse that rises, with `busy` falling, N*CLK_DIV clocks after the edge that accepted the start, where N is 64 or 32.
- R9: A `cmdStart` pulse while `busy` is high is ignored: the running frame continues unchanged, and no extra frame or `done` follows.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low synchronous reset |
| cmdStart | input | 1 | One-clock request to begin a transaction |
| cmdRead | input | 1 | 1 = read, 0 = write |
| cmdPhyAddr | input | 5 | Target PHY address |
| cmdRegAddr | input | 5 | Target register address |
| cmdWrData | input | 16 | Data for a write |
| cmdNoPre | input | 1 | 1 = omit the 32-bit preamble |
| mdioIn | input | 1 | Sensed level of the management data line |
| mdc | output | 1 | Management clock, low when idle |
| mdioOut | output | 1 | Value to drive on the data line |
| mdioOe | output | 1 | Driver enable for the data line |
| busy | output | 1 | Transaction in progress |
| done | output | 1 | One-clock completion pulse |
| rdData | output | 16 | Data captured by the last read |
| noResp | output | 1 | Last read saw no turnaround response |

## Verification
The assertions assume that `cmdStart` is a single-clock pulse synchronous to `clk`. They also assume that `mdioIn` changes only between MDC rising edges and never in the clock where the master samples it. The bench meets both conditions. Its PHY model computes the line level from a count of MDC rises that it updates one clock after each rise. It drives command inputs only on falling system-clock edges, and it models the pull-up by reading 1 whenever nobody drives the line.

// File: rtl/mdio_pkg.sv
package mdio_pkg;
  localparam int ADDR_W    = 5;
  localparam int DATA_W    = 16;
  localparam int PRE_LEN   = 32;
  localparam int HDR_LEN   = 4 + 2 * ADDR_W;
  localparam int FRAME_LEN = HDR_LEN + 2 + DATA_W;
  localparam int TOTAL_LEN = PRE_LEN + FRAME_LEN;

  typedef struct packed {
    logic load;    // capture command, present first bit
    logic shift;   // advance to next outgoing bit (MDC falls)
    logic sample;  // capture mdioIn (MDC rises)
    logic mdcHi;
    logic mdcLo;
    logic finish;  // last bit complete
  } strobe_t;
endpackage

// File: rtl/mdio_ctrl.sv
module mdio_ctrl
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    cmdStart,
  input  logic    cmdNoPre,
  output strobe_t stb,
  output logic    busy
);
  localparam int HALF  = CLK_DIV / 2;
  localparam int PH_W  = $clog2(CLK_DIV);
  localparam int CNT_W = $clog2(TOTAL_LEN);

  typedef enum logic {IDLE, RUN} state_t;

  state_t           state;
  logic [PH_W-1:0]  phase;
  logic [CNT_W-1:0] bitsLeft;
  logic             atRise;
  logic             atEnd;
  logic             lastBit;

  assign atRise  = phase == PH_W'(HALF - 1);
  assign atEnd   = phase == PH_W'(CLK_DIV - 1);
  assign lastBit = bitsLeft == '0;
  assign busy    = state == RUN;

  always_comb begin
    stb      = '0;
    stb.load = (state == IDLE) && cmdStart;
    if (state == RUN) begin
      stb.sample = atRise;
      stb.mdcHi  = atRise;
      stb.mdcLo  = atEnd;
      stb.finish = atEnd && lastBit;
      stb.shift  = atEnd && !lastBit;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state    <= IDLE;
      phase    <= '0;
      bitsLeft <= '0;
    end else if (state == IDLE) begin
      if (cmdStart) begin
        state    <= RUN;
        phase    <= '0;
        bitsLeft <= cmdNoPre ? CNT_W'(FRAME_LEN - 1) : CNT_W'(TOTAL_LEN - 1);
      end
    end else if (atEnd) begin
      phase <= '0;
      if (lastBit) state <= IDLE;
      else         bitsLeft <= bitsLeft - CNT_W'(1);
    end else begin
      phase <= phase + PH_W'(1);
    end
  end
endmodule

// File: rtl/mdio_dp.sv
module mdio_dp
  import mdio_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           stb,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdPhyAddr,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic              cmdNoPre,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic [DATA_W-1:0] rdData,
  output logic              done,
  output logic              noResp
);
  logic [TOTAL_LEN-1:0] txShift;
  logic [TOTAL_LEN-1:0] oeShift;
  logic [DATA_W:0]      rxShift;
  logic                 isRead;
  logic [FRAME_LEN-1:0] frameBits;
  logic [FRAME_LEN-1:0] frameOe;
  logic [1:0]           opBits;
  logic [1:0]           taBits;
  logic [DATA_W-1:0]    dataBits;

  always_comb begin
    opBits    = cmdRead ? 2'b10 : 2'b01;
    taBits    = cmdRead ? 2'b00 : 2'b10;
    dataBits  = cmdRead ? '0 : cmdWrData;
    frameBits = {2'b01, opBits, cmdPhyAddr, cmdRegAddr, taBits, dataBits};
    frameOe   = cmdRead ? {{HDR_LEN{1'b1}}, {(FRAME_LEN - HDR_LEN){1'b0}}}
                        : {FRAME_LEN{1'b1}};
  end

  assign mdioOut = txShift[TOTAL_LEN-1];
  assign mdioOe  = oeShift[TOTAL_LEN-1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      txShift <= '0;
      oeShift <= '0;
      isRead  <= 1'b0;
    end else if (stb.load) begin
      isRead <= cmdRead;
      if (cmdNoPre) begin
        txShift <= {frameBits, {PRE_LEN{1'b0}}};
        oeShift <= {frameOe, {PRE_LEN{1'b0}}};
      end else begin
        txShift <= {{PRE_LEN{1'b1}}, frameBits};
        oeShift <= {{PRE_LEN{1'b1}}, frameOe};
      end
    end else if (stb.shift) begin
      txShift <= {txShift[TOTAL_LEN-2:0], 1'b0};
      oeShift <= {oeShift[TOTAL_LEN-2:0], 1'b0};
    end else if (stb.finish) begin
      oeShift <= '0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN)          mdc <= 1'b0;
    else if (stb.mdcLo) mdc <= 1'b0;
    else if (stb.mdcHi) mdc <= 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rstN)           rxShift <= '0;
    else if (stb.sample) rxShift <= {rxShift[DATA_W-1:0], mdioIn};
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      done   <= 1'b0;
      noResp <= 1'b0;
      rdData <= '0;
    end else begin
      done <= stb.finish;
      if (stb.finish) begin
        noResp <= isRead && rxShift[DATA_W];
        if (isRead) rdData <= rxShift[DATA_W] ? '1 : rxShift[DATA_W-1:0];
      end
    end
  end
endmodule

// File: rtl/mdio_master.sv
module mdio_master
  import mdio_pkg::*;
#(
  parameter int CLK_DIV = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              cmdStart,
  input  logic              cmdRead,
  input  logic [ADDR_W-1:0] cmdPhyAddr,
  input  logic [ADDR_W-1:0] cmdRegAddr,
  input  logic [DATA_W-1:0] cmdWrData,
  input  logic              cmdNoPre,
  input  logic              mdioIn,
  output logic              mdc,
  output logic              mdioOut,
  output logic              mdioOe,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rdData,
  output logic              noResp
);
  strobe_t stb;

  mdio_ctrl #(.CLK_DIV(CLK_DIV)) i_ctrl (
    .clk      (clk),
    .rstN     (rstN),
    .cmdStart (cmdStart),
    .cmdNoPre (cmdNoPre),
    .stb      (stb),
    .busy     (busy)
  );

  mdio_dp i_dp (
    .clk        (clk),
    .rstN       (rstN),
    .stb        (stb),
    .cmdRead    (cmdRead),
    .cmdPhyAddr (cmdPhyAddr),
    .cmdRegAddr (cmdRegAddr),
    .cmdWrData  (cmdWrData),
    .cmdNoPre   (cmdNoPre),
    .mdioIn     (mdioIn),
    .mdc        (mdc),
    .mdioOut    (mdioOut),
    .mdioOe     (mdioOe),
    .rdData     (rdData),
    .done       (done),
    .noResp     (noResp)
  );
endmodule

// File: rtl/mdio_master_chk.sv
module mdio_master_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdStart,
  input logic        busy,
  input logic        done,
  input logic        noResp,
  input logic [15:0] rdData,
  input logic        mdc,
  input logic        mdioOut,
  input logic        mdioOe
);
  a_r1_idle_quiet: assert property (@(posedge clk) disable iff (!rstN)
    !busy |-> (!mdc && !mdioOe));

  a_r7_stable_at_rise: assert property (@(posedge clk) disable iff (!rstN)
    $rose(mdc) |-> ($stable(mdioOut) && $stable(mdioOe)));

  a_r7_change_on_fall: assert property (@(posedge clk) disable iff (!rstN)
    (busy && $past(busy) && !$stable(mdioOut)) |-> $fell(mdc));

  a_r8_done_pulse: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  a_r8_done_ends_busy: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (!busy && $past(busy)));

  a_r9_start_only_idle: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(cmdStart));

  a_r6_noresp_ones: assert property (@(posedge clk) disable iff (!rstN)
    (done && noResp) |-> (rdData == 16'hFFFF));
endmodule

bind mdio_master mdio_master_chk u_chk (.*);

// File: tb/test_mdio_master.sv
`timescale 1ns/1ps
module test_mdio_master;
  localparam int CLK_DIV = 8;
  localparam int HALF    = CLK_DIV / 2;

  typedef struct packed {
    logic        rd;
    logic        sup;
    logic [4:0]  phy;
    logic [4:0]  rg;
    logic [15:0] wd;
    logic        resp;
    logic [15:0] pd;
    logic [15:0] ed;
    logic        enr;
  } vec_t;

  localparam int NV = 7;
  localparam vec_t VEC [NV] = '{
    '{1'b0, 1'b0, 5'h01, 5'h00, 16'h1234, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{1'b0, 1'b1, 5'h1F, 5'h1F, 16'hA5C3, 1'b0, 16'h0000, 16'h0000, 1'b0},
    '{1'b1, 1'b0, 5'h03, 5'h01, 16'h0000, 1'b1, 16'h796D, 16'h796D, 1'b0},
    '{1'b1, 1'b1, 5'h10, 5'h02, 16'h0000, 1'b1, 16'h8001, 16'h8001, 1'b0},
    '{1'b1, 1'b0, 5'h0A, 5'h15, 16'h0000, 1'b0, 16'h0000, 16'hFFFF, 1'b1},
    '{1'b0, 1'b0, 5'h05, 5'h04, 16'h0F0F, 1'b0, 16'h0000, 16'hFFFF, 1'b0},
    '{1'b1, 1'b1, 5'h00, 5'h1E, 16'h0000, 1'b1, 16'h0000, 16'h0000, 1'b0}
  };

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic cmdStart = 1'b0, cmdRead = 1'b0, cmdNoPre = 1'b0;
  logic [4:0] cmdPhyAddr = '0, cmdRegAddr = '0;
  logic [15:0] cmdWrData = '0;
  logic mdioIn, mdc, mdioOut, mdioOe, busy, done, noResp;
  logic [15:0] rdData;

  always #2 clk = ~clk;

  // PHY model state
  logic respond = 1'b0, isRd = 1'b0;
  int preLen = 32;
  logic [15:0] phyData = '0;
  int riseCnt = 0, drvCnt = 0;
  logic [63:0] cap = '0;
  logic mdcPrev = 1'b0;
  logic inWin;

  assign inWin  = respond && isRd && (riseCnt >= preLen + 15) && (riseCnt <= preLen + 31);
  assign mdioIn = mdioOe ? mdioOut
                : (inWin ? ((riseCnt == preLen + 15) ? 1'b0 : phyData[preLen + 31 - riseCnt])
                         : 1'b1);

  mdio_master #(.CLK_DIV(CLK_DIV)) i_mdio_master (
    .clk(clk), .rstN(rstN), .cmdStart(cmdStart), .cmdRead(cmdRead),
    .cmdPhyAddr(cmdPhyAddr), .cmdRegAddr(cmdRegAddr), .cmdWrData(cmdWrData),
    .cmdNoPre(cmdNoPre), .mdioIn(mdioIn), .mdc(mdc), .mdioOut(mdioOut),
    .mdioOe(mdioOe), .busy(busy), .done(done), .rdData(rdData), .noResp(noResp)
  );

  always @(posedge clk) begin
    if (cmdStart && !busy) begin
      riseCnt = 0; drvCnt = 0; cap = '0;
    end else if (mdc && !mdcPrev) begin
      riseCnt++;
      if (mdioOe) begin
        cap = {cap[62:0], mdioOut};
        drvCnt++;
      end
    end
    mdcPrev = mdc;
  end

  // line-level monitors
  int r7Err = 0, hiRun = 0, hiBad = 0, hiSeen = 0, idleBad = 0, doneCnt = 0;
  logic prevO = 1'b0, prevOe = 1'b0;
  always @(negedge clk) begin
    if (rstN) begin
      if (mdc && (mdioOut !== prevO || mdioOe !== prevOe)) r7Err++;
      if (mdc) hiRun++;
      else if (hiRun > 0) begin
        hiSeen++;
        if (hiRun != HALF) hiBad++;
        hiRun = 0;
      end
      if (!busy && (mdc || mdioOe)) idleBad++;
      if (done) doneCnt++;
    end
    prevO = mdioOut; prevOe = mdioOe;
  end

  int tests = 0, fails = 0;
  logic finished = 1'b0;

  task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  // expected driven bit stream from the requirements
  task automatic expBits(input vec_t v, output logic [63:0] e, output int n);
    logic [13:0] hdr;
    e = '0; n = 0;
    if (!v.sup) for (int i = 0; i < 32; i++) begin e = {e[62:0], 1'b1}; n++; end
    hdr = {2'b01, (v.rd ? 2'b10 : 2'b01), v.phy, v.rg};
    for (int i = 13; i >= 0; i--) begin e = {e[62:0], hdr[i]}; n++; end
    if (!v.rd) begin
      e = {e[62:0], 1'b1}; e = {e[62:0], 1'b0}; n += 2;
      for (int i = 15; i >= 0; i--) begin e = {e[62:0], v.wd[i]}; n++; end
    end
  endtask

  task automatic startCmd(input vec_t v);
    @(negedge clk);
    cmdRead = v.rd; cmdNoPre = v.sup; cmdPhyAddr = v.phy; cmdRegAddr = v.rg;
    cmdWrData = v.wd; cmdStart = 1'b1;
    respond = v.resp; isRd = v.rd; preLen = v.sup ? 0 : 32; phyData = v.pd;
    @(negedge clk);
    cmdStart = 1'b0;
  endtask

  task automatic waitDone(output int cyc);
    cyc = 1;
    while (!done && cyc < 5000) begin @(negedge clk); cyc++; end
  endtask

  task automatic runVec(input vec_t v, input int idx);
    int cyc, n, nb;
    logic [63:0] e;
    startCmd(v);
    waitDone(cyc);
    nb = v.sup ? 32 : 64;
    expBits(v, e, n);
    chk($sformatf("R8 vec%0d done latency", idx), 64'(cyc), 64'(nb * CLK_DIV + 1));
    chk($sformatf("R2 vec%0d mdc rises", idx), 64'(riseCnt), 64'(nb));
    chk($sformatf("R5 vec%0d driven bit count", idx), 64'(drvCnt), 64'(n));
    chk($sformatf("R3 R4 vec%0d driven stream", idx), cap, e);
    chk($sformatf("R8 vec%0d busy low at done", idx), 64'(busy), 64'(0));
    chk($sformatf("R6 vec%0d noResp", idx), 64'(noResp), 64'(v.enr));
    if (v.rd) chk($sformatf("R5 vec%0d rdData", idx), 64'(rdData), 64'(v.ed));
    @(negedge clk);
    chk($sformatf("R8 vec%0d done one cycle", idx), 64'(done), 64'(0));
  endtask

  initial begin
    int cyc, dc;
    logic [63:0] e;
    int n;
    vec_t rdV, wrV;
    repeat (5) @(negedge clk);
    // R1 reset state
    chk("R1 reset busy", 64'(busy), 64'(0));
    chk("R1 reset done", 64'(done), 64'(0));
    chk("R1 reset noResp", 64'(noResp), 64'(0));
    chk("R1 reset mdc/oe", {62'(0), mdc, mdioOe}, 64'(0));
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    chk("R1 idle after reset mdc/oe", {62'(0), mdc, mdioOe}, 64'(0));

    for (int i = 0; i < NV; i++) runVec(VEC[i], i);

    // R9: start request during a running frame is ignored
    rdV = '{1'b1, 1'b0, 5'h12, 5'h07, 16'h0000, 1'b1, 16'hC0DE, 16'hC0DE, 1'b0};
    wrV = '{1'b0, 1'b1, 5'h01, 5'h01, 16'hFFFF, 1'b0, 16'h0000, 16'h0000, 1'b0};
    dc = doneCnt;
    startCmd(rdV);
    repeat (100) @(negedge clk);
    cmdRead = wrV.rd; cmdNoPre = wrV.sup; cmdPhyAddr = wrV.phy;
    cmdRegAddr = wrV.rg; cmdWrData = wrV.wd; cmdStart = 1'b1;
    @(negedge clk);
    cmdStart = 1'b0;
    waitDone(cyc);
    expBits(rdV, e, n);
    chk("R9 frame unchanged by busy start", cap, e);
    chk("R9 read data of first command", 64'(rdData), 64'(16'hC0DE));
    repeat (300) @(negedge clk);
    chk("R9 no second frame", 64'(riseCnt), 64'(64));
    chk("R9 single done", 64'(doneCnt - dc), 64'(1));
    chk("R9 idle after ignore", 64'(busy), 64'(0));

    chk("R1 idle line quiet", 64'(idleBad), 64'(0));
    chk("R7 no output change while mdc high", 64'(r7Err), 64'(0));
    chk("R8 mdc high phase length", 64'(hiBad), 64'(0));
    chk("R8 mdc high phases seen", 64'(hiSeen > 0), 64'(1));

    if (!finished) begin
      finished = 1'b1;
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      tests++; fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule